// File: doc/BRIEF.md
# Selectable LRU Victim Selector

This block holds the replacement history of a set-associative cache and names the way to fill when a lookup misses. For each set it keeps two kinds of history side by side: a full recency rank per way, and one recently-used flag per way. A policy input, which may change at any time, picks which history decides the victim. A way that is not valid is always taken first, before either history is consulted.

The cache controller drives a lookup set index together with that set's valid vector and reads back the victim way in the same cycle, with no register in the path. Whenever a way is hit or filled, the controller raises a touch naming the set and the way, and both histories take the update on that clock edge. Invalidating a line needs no call into this block: the controller clears the valid bit, and the stored history stays as it is.

Top module: `lru_victim_sel`

## Requirements
- R1: The policy input chooses the victim rule when every way of the looked-up set is valid: 0 selects true LRU and 1 selects the one-flag-per-way approximation.
- R2: If any way of the looked-up set is invalid (its valid bit is 0), the victim is the lowest-numbered invalid way, under either policy.
- R3: Under true LRU with all ways valid, the victim is the way touched least recently. A touch makes the touched way the most recent, and each way that was more recent than it moves one place older.
- R4: Under the one-flag policy, a touch sets the flag of the touched way. If that would leave every flag of the set at 1, all flags except the touched one are cleared. With all ways valid, the victim is the lowest-numbered way whose flag is 0, or way 0 if none is 0.
- R5: After reset every set ranks way 0 as least recent, then way 1, up to the highest way as most recent, and every flag is 0.
- R6: The history changes only on a clock edge where the touch input is high. The victim output is combinational from the lookup inputs and the history stored before the current edge, so a touch to the looked-up set is seen from the next cycle on.
- R7: A touch changes the history of the named set only.
- R8: Both histories take every touch whatever the policy input is, so a change of policy takes effect at once and uses the full history.
- R9: With one way per set the victim is always way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_sel | input | 1 | 0 true LRU, 1 one-flag approximation |
| lookup_set | input | SET_W | Set whose victim is requested |
| valid_vec | input | NUM_WAYS | Valid bits of the looked-up set, bit i for way i |
| victim_way | output | WAY_W | Way to fill in the looked-up set |
| touch_en | input | 1 | A way was hit or filled this cycle |
| touch_set | input | SET_W | Set of the touched way |
| touch_way | input | WAY_W | Touched way |

## Verification
A lookup and a touch can fall in the same cycle on the same set, so the victim read must reflect the history from before the touch while the update lands at the edge. The bench provokes this on every touch it issues: it holds the lookup on the touched set with all ways valid and compares the victim, before the edge, with a model that has not yet applied the touch, then checks the effect in later cycles. Each set is swept through a fixed touch sequence, all sixteen valid patterns are applied under both policies, and a one-way instance is exercised separately.

// File: rtl/lru_sel_pkg.sv
package lru_sel_pkg;

    typedef enum logic {
        POL_TRUE_LRU = 1'b0,
        POL_ONE_BIT  = 1'b1
    } lru_policy_e;

    // Index width that never falls to zero bits.
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lru_age_store.sv
module lru_age_store #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = lru_sel_pkg::idx_width(NUM_SETS),
    localparam int WAY_W = lru_sel_pkg::idx_width(NUM_WAYS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             touch_en,
    input  logic [SET_W-1:0]                 touch_set,
    input  logic [WAY_W-1:0]                 touch_way,
    input  logic [SET_W-1:0]                 rd_set,
    output logic [NUM_WAYS-1:0][WAY_W-1:0]   rd_age
);

    typedef logic [NUM_WAYS-1:0][WAY_W-1:0] age_row_t;

    typedef struct packed {
        age_row_t [NUM_SETS-1:0] age;
    } age_state_t;

    age_state_t state_d, state_q;
    age_row_t   row_cur;
    logic [WAY_W-1:0] touched_age;

    // Age 0 is most recent, NUM_WAYS-1 is least recent.
    always_comb begin
        state_d     = state_q;
        row_cur     = state_q.age[touch_set];
        touched_age = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (WAY_W'(w) == touch_way) begin
                touched_age = row_cur[w];
            end
        end
        if (touch_en) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    state_d.age[touch_set][w] = '0;
                end else if (row_cur[w] < touched_age) begin
                    state_d.age[touch_set][w] = row_cur[w] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    state_q.age[s][w] <= WAY_W'(NUM_WAYS - 1 - w);
                end
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_age = state_q.age[rd_set];

    assert_touch_mru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (state_q.age[$past(touch_set)][$past(touch_way)] == '0));

    assert_hold_without_touch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_en |=> $stable(state_q));

endmodule

// File: rtl/lru_bit_store.sv
module lru_bit_store #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = lru_sel_pkg::idx_width(NUM_SETS),
    localparam int WAY_W = lru_sel_pkg::idx_width(NUM_WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 touch_en,
    input  logic [SET_W-1:0]     touch_set,
    input  logic [WAY_W-1:0]     touch_way,
    input  logic [SET_W-1:0]     rd_set,
    output logic [NUM_WAYS-1:0]  rd_bits
);

    typedef struct packed {
        logic [NUM_SETS-1:0][NUM_WAYS-1:0] used;
    } bit_state_t;

    bit_state_t state_d, state_q;
    logic [NUM_WAYS-1:0] row_nxt;
    logic [NUM_WAYS-1:0] touch_hot;

    always_comb begin
        state_d   = state_q;
        touch_hot = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (WAY_W'(w) == touch_way) begin
                touch_hot[w] = 1'b1;
            end
        end
        row_nxt = state_q.used[touch_set] | touch_hot;
        if (&row_nxt) begin
            row_nxt = touch_hot;
        end
        if (touch_en) begin
            state_d.used[touch_set] = row_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_bits = state_q.used[rd_set];

    assert_flag_set_on_touch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> state_q.used[$past(touch_set)][$past(touch_way)]);

    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_en |=> $stable(state_q));

    generate
        if (NUM_WAYS > 1) begin : g_not_full
            assert_never_all_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
                touch_en |=> !(&state_q.used[$past(touch_set)]));
        end
    endgenerate

endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
    import lru_sel_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = lru_sel_pkg::idx_width(NUM_WAYS)
) (
    input  lru_policy_e                      policy,
    input  logic [NUM_WAYS-1:0]              valid_vec,
    input  logic [NUM_WAYS-1:0][WAY_W-1:0]   ages,
    input  logic [NUM_WAYS-1:0]              used,
    output logic [WAY_W-1:0]                 victim
);

    logic [WAY_W-1:0] inv_way, lru_way, bit_way;
    logic             inv_found, bit_found;

    always_comb begin
        inv_way   = '0;
        inv_found = 1'b0;
        lru_way   = '0;
        bit_way   = '0;
        bit_found = 1'b0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!inv_found && !valid_vec[w]) begin
                inv_way   = WAY_W'(w);
                inv_found = 1'b1;
            end
            if (ages[w] == WAY_W'(NUM_WAYS - 1)) begin
                lru_way = WAY_W'(w);
            end
            if (!bit_found && !used[w]) begin
                bit_way   = WAY_W'(w);
                bit_found = 1'b1;
            end
        end
        if (inv_found) begin
            victim = inv_way;
        end else if (policy == POL_TRUE_LRU) begin
            victim = lru_way;
        end else begin
            victim = bit_way;
        end
    end

endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel
    import lru_sel_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = lru_sel_pkg::idx_width(NUM_SETS),
    localparam int WAY_W = lru_sel_pkg::idx_width(NUM_WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 policy_sel,
    input  logic [SET_W-1:0]     lookup_set,
    input  logic [NUM_WAYS-1:0]  valid_vec,
    output logic [WAY_W-1:0]     victim_way,
    input  logic                 touch_en,
    input  logic [SET_W-1:0]     touch_set,
    input  logic [WAY_W-1:0]     touch_way
);

    logic [NUM_WAYS-1:0][WAY_W-1:0] rd_age;
    logic [NUM_WAYS-1:0]            rd_bits;
    lru_policy_e                    policy;

    assign policy = lru_policy_e'(policy_sel);

    lru_age_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_age (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(touch_set),
        .touch_way(touch_way), .rd_set(lookup_set), .rd_age(rd_age)
    );

    lru_bit_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_bits (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(touch_set),
        .touch_way(touch_way), .rd_set(lookup_set), .rd_bits(rd_bits)
    );

    lru_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .policy(policy), .valid_vec(valid_vec), .ages(rd_age),
        .used(rd_bits), .victim(victim_way)
    );

    assert_fill_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid_vec) |-> !valid_vec[victim_way]);

    assert_lru_victim_oldest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((&valid_vec) && !policy_sel) |-> (rd_age[victim_way] == WAY_W'(NUM_WAYS - 1)));

    assert_bit_victim_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((&valid_vec) && policy_sel && !(&rd_bits)) |-> !rd_bits[victim_way]);

endmodule

// File: tb/lru_victim_sel_bench.sv
module lru_victim_sel_bench;

    localparam int NS = 16;
    localparam int NW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       policy_sel = 1'b0;
    logic [3:0] lookup_set = '0;
    logic [3:0] valid_vec = '0;
    logic [1:0] victim_way;
    logic       touch_en = 1'b0;
    logic [3:0] touch_set = '0;
    logic [1:0] touch_way = '0;

    logic       s_valid = 1'b0;
    logic       s_touch_en = 1'b0;
    logic [0:0] s_victim;

    int checks = 0;
    int errors = 0;
    int m_age [NS][NW];
    bit m_bit [NS][NW];

    always #2.5 clk = ~clk;

    lru_victim_sel #(.NUM_SETS(NS), .NUM_WAYS(NW)) u_lru_victim_sel (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .lookup_set(lookup_set),
        .valid_vec(valid_vec), .victim_way(victim_way), .touch_en(touch_en),
        .touch_set(touch_set), .touch_way(touch_way)
    );

    lru_victim_sel #(.NUM_SETS(2), .NUM_WAYS(1)) u_single (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .lookup_set(1'b0),
        .valid_vec(s_valid), .victim_way(s_victim), .touch_en(s_touch_en),
        .touch_set(1'b1), .touch_way(1'b0)
    );

    function automatic int expect_victim(int s, logic [3:0] v, bit pol);
        for (int i = 0; i < NW; i++) if (!v[i]) return i;
        if (!pol) begin
            for (int i = 0; i < NW; i++) if (m_age[s][i] == NW - 1) return i;
        end else begin
            for (int i = 0; i < NW; i++) if (!m_bit[s][i]) return i;
        end
        return 0;
    endfunction

    task automatic model_touch(int s, int w);
        int a = m_age[s][w];
        bit full = 1'b1;
        for (int i = 0; i < NW; i++) if (m_age[s][i] < a) m_age[s][i]++;
        m_age[s][w] = 0;
        m_bit[s][w] = 1'b1;
        for (int i = 0; i < NW; i++) if (!m_bit[s][i]) full = 1'b0;
        if (full) for (int i = 0; i < NW; i++) m_bit[s][i] = (i == w);
    endtask

    task automatic compare(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: victim %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic lookup(int s, logic [3:0] v, bit pol, string tag);
        @(negedge clk);
        lookup_set = 4'(s);
        valid_vec  = v;
        policy_sel = pol;
        #1;
        compare(int'(victim_way), expect_victim(s, v, pol), tag);
    endtask

    // Touch with a same-cycle lookup of the touched set (R6).
    task automatic touch(int s, int w);
        @(negedge clk);
        touch_en   = 1'b1;
        touch_set  = 4'(s);
        touch_way  = 2'(w);
        lookup_set = 4'(s);
        valid_vec  = 4'hF;
        policy_sel = 1'b0;
        #1;
        compare(int'(victim_way), expect_victim(s, 4'hF, 1'b0), "R6 same-cycle lookup sees pre-touch order");
        @(posedge clk);
        model_touch(s, w);
        @(negedge clk);
        touch_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                m_age[s][w] = NW - 1 - w;
                m_bit[s][w] = 1'b0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: reset order, both policies, all sets.
        for (int s = 0; s < NS; s++) begin
            lookup(s, 4'hF, 1'b0, "R5 reset true-LRU victim");
            lookup(s, 4'hF, 1'b1, "R5 reset flag victim");
        end

        // R9: single-way instance.
        s_valid = 1'b1;
        @(negedge clk); #1;
        compare(int'(s_victim), 0, "R9 one way all valid");
        s_touch_en = 1'b1;
        @(negedge clk); s_touch_en = 1'b0; #1;
        compare(int'(s_victim), 0, "R9 one way after touch");
        s_valid = 1'b0; #1;
        compare(int'(s_victim), 0, "R9 one way invalid");

        for (int s = 0; s < NS; s++) begin
            // R7: this set untouched so far, still in reset order.
            lookup(s, 4'hF, 1'b0, "R7 untouched set keeps reset order");
            if (s > 0) lookup(s - 1, 4'hF, 1'b1, "R7 earlier set unchanged by idle");
            for (int k = 0; k < 12; k++) begin
                touch(s, (s * 3 + k * 5 + k / 3) % NW);
                lookup(s, 4'hF, 1'b0, "R3 true-LRU victim after touch");
                lookup(s, 4'hF, 1'b1, "R8 flag victim under switched policy");
                lookup(s, 4'hF, 1'b1, "R4 flag victim stable");
                lookup(s, 4'hF, 1'b0, "R1 policy 0 selects true LRU");
            end
            for (int v = 0; v < 16; v++) begin
                lookup(s, 4'(v), 1'b0, "R2 invalid-first under true LRU");
                lookup(s, 4'(v), 1'b1, "R2 invalid-first under flag policy");
            end
            repeat (3) @(negedge clk);
            lookup(s, 4'hF, 1'b0, "R6 history holds without touch");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule